// File: doc/BRIEF.md
# Trapezoidal Pulse Shaping Filter

This block is a streaming fixed-point shaper for pulses from a charge-sensitive detector. Each pulse is an exponential decay. One signed input sample arrives with each `in_valid` strobe. The filter is a cascade of four registered stages:

1. A pole-zero section that cancels the exponential decay and turns each pulse into a step.
2. A difference stage over a programmable distance of k samples.
3. A difference stage over a single sample.
4. An accumulator with a one-sample delay, followed by a fixed-point gain, a rounding shift and saturation.

The pole-zero section comes first and the accumulator comes last. This keeps intermediate growth bounded. The two difference stages in the middle commute.

The decay coefficient, the distance k, the gain and the shift are inputs that can change at runtime. Feed in an exponential whose decay matches the coefficient, and the output is a flat-topped pulse. The pulse lasts k samples, and its height is the pulse amplitude times the gain. Before and after the pulse the output sits on a zero baseline. How flat the top is depends on how precisely the coefficient is quantized. For that reason the coefficient carries 15 fractional bits.

Top module: `trap_shaper`

## Requirements
- R1: Each `in_valid` sample produces an `out_valid` strobe exactly 4 clock cycles later, and `out_valid` is never raised without such a sample. This holds unless a clear intervenes.
- R2: Cycles with `in_valid` low change no state. `out_data` holds its last value until the next `out_valid`.
- R3: The input is an exponential x[0]=A, x[n+1]=floor(x[n]·q/32768), with the matching q. With unity gain (32768) and shift 0, exactly k outputs equal A. All other outputs of the pulse are 0, including the final one.
- R4: The output is floor((acc·gain + 2^(14+s)) / 2^(15+s)). Here gain is unsigned Q1.15 (32768 = 1.0), s is `gain_shift`, and acc is the accumulator. This is round to nearest, with halves rounded toward +infinity.
- R5: Results above 2^(OW−1)−1 or below −2^(OW−1) saturate to those limits instead of wrapping.
- R6: The difference distance is `dly_k` for 1..256. A value of 0 acts as 1, and any value above 256 acts as 256.
- R7: In the clock edge after `dly_k` changes, every stage and the delay line clear to zero. In the next cycle `out_valid` is 0 and `out_data` is 0, and later outputs start from the zero state.
- R8: Synchronous active-high `rst` clears all state, so `out_valid` and `out_data` are 0 in the cycle after it.
- R9: For any input, output n equals the sum over j<n of y3[j], passed through the R4 scaling. The terms are y1[n]=y1[n−1]+x[n]−floor(q·x[n−1]/32768), y2[n]=y1[n]−y1[n−k] and y3[n]=y2[n]−y2[n−1], with q unsigned Q1.15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IW | Signed input sample |
| q_coef | input | 16 | Decay coefficient, unsigned Q1.15 |
| dly_k | input | KW | Difference distance k (KW = clog2(KMAX)+1) |
| gain | input | 16 | Output gain, unsigned Q1.15 |
| gain_shift | input | 4 | Extra arithmetic right shift after the gain |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | OW | Signed, saturated output sample |

## Verification
The bench builds the block with its defaults: 16-bit input and output and a delay line 256 deep. This makes the full k range reachable, from the degenerate k of 0 or 1 up to the clamp of an oversized k onto 256. The 16-bit output lets a modest integrating input reach both saturation limits within a few samples. The 4-bit shift and the gain span reach both the halfway rounding cases, positive and negative, and a top that is exactly divided.

// File: rtl/trap_pkg.sv
package trap_pkg;

    // Fixed-point format of the coefficient and gain inputs: unsigned Q1.15
    localparam int QFRAC = 15;
    localparam int QW    = QFRAC + 1;
    localparam int SHW   = 4;

    typedef logic [QW-1:0]  ufix_t;
    typedef logic [SHW-1:0] shamt_t;

    // Output scaling settings travel together through the last stage
    typedef struct packed {
        ufix_t  gain;
        shamt_t shift;
    } scale_cfg_t;

    // Guard bits that internal accumulators carry over the input width
    function automatic int guard_bits(input int kmax);
        return $clog2(kmax) + 2;
    endfunction

endpackage

// File: rtl/trap_pole_zero.sv
module trap_pole_zero
    import trap_pkg::*;
#(
    parameter int IW = 16,
    parameter int AW = 26
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 in_v,
    input  logic signed [IW-1:0] x,
    input  ufix_t                q,
    output logic                 out_v,
    output logic signed [AW-1:0] y
);
    localparam int PXW = IW + QW + 1;

    logic signed [IW-1:0]  xp;
    logic signed [PXW-1:0] xa, qa, prod;
    logic signed [AW-1:0]  qx, x_ext;

    always_comb begin
        xa    = PXW'(xp);
        qa    = PXW'($signed({1'b0, q}));
        prod  = xa * qa;
        qx    = AW'(prod >>> QFRAC);
        x_ext = AW'(x);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            xp    <= '0;
            y     <= '0;
            out_v <= 1'b0;
        end else begin
            out_v <= in_v;
            if (in_v) begin
                xp <= x;
                y  <= y + x_ext - qx;
            end
        end
    end
endmodule

// File: rtl/trap_delay_diff.sv
module trap_delay_diff #(
    parameter  int AW    = 26,
    parameter  int DEPTH = 256,
    localparam int KW    = $clog2(DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 in_v,
    input  logic signed [AW-1:0] d,
    input  logic [KW-1:0]        k,
    output logic                 out_v,
    output logic signed [AW-1:0] y
);
    localparam int PW = $clog2(DEPTH);

    logic signed [AW-1:0] ring [DEPTH];
    logic [PW-1:0]        wp, rp;
    logic [KW-1:0]        keff;

    always_comb begin
        if (k == '0)
            keff = KW'(1);
        else if (k > KW'(DEPTH))
            keff = KW'(DEPTH);
        else
            keff = k;
        rp = wp - keff[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wp    <= '0;
            y     <= '0;
            out_v <= 1'b0;
            for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
        end else begin
            out_v <= in_v;
            if (in_v) begin
                ring[wp] <= d;
                wp       <= wp + 1'b1;
                y        <= d - ring[rp];
            end
        end
    end
endmodule

// File: rtl/trap_first_diff.sv
module trap_first_diff #(
    parameter int AW = 26
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 in_v,
    input  logic signed [AW-1:0] d,
    output logic                 out_v,
    output logic signed [AW-1:0] y
);
    logic signed [AW-1:0] dp;

    always_ff @(posedge clk) begin
        if (clr) begin
            dp    <= '0;
            y     <= '0;
            out_v <= 1'b0;
        end else begin
            out_v <= in_v;
            if (in_v) begin
                dp <= d;
                y  <= d - dp;
            end
        end
    end
endmodule

// File: rtl/trap_accum_scale.sv
module trap_accum_scale
    import trap_pkg::*;
#(
    parameter int AW = 26,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 in_v,
    input  logic signed [AW-1:0] d,
    input  scale_cfg_t           cfg,
    output logic                 out_v,
    output logic signed [OW-1:0] y
);
    localparam int PRW = AW + QW + 1;
    localparam logic signed [PRW-1:0] MAXV = PRW'((64'sd1 <<< (OW-1)) - 1);
    localparam logic signed [PRW-1:0] MINV = ~MAXV;

    logic signed [AW-1:0]  acc, dp, acc_n;
    logic signed [PRW-1:0] aa, ga, prod, rnd, shv;
    logic signed [OW-1:0]  sat_v;

    always_comb begin
        acc_n = acc + dp;
        aa    = PRW'(acc_n);
        ga    = PRW'($signed({1'b0, cfg.gain}));
        prod  = aa * ga;
        rnd   = PRW'(1) <<< (QFRAC - 1 + int'(cfg.shift));
        shv   = (prod + rnd) >>> (QFRAC + int'(cfg.shift));
        if (shv > MAXV)
            sat_v = OW'(MAXV);
        else if (shv < MINV)
            sat_v = OW'(MINV);
        else
            sat_v = OW'(shv);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            acc   <= '0;
            dp    <= '0;
            y     <= '0;
            out_v <= 1'b0;
        end else begin
            out_v <= in_v;
            if (in_v) begin
                acc <= acc_n;
                dp  <= d;
                y   <= sat_v;
            end
        end
    end
endmodule

// File: rtl/trap_shaper.sv
module trap_shaper
    import trap_pkg::*;
#(
    parameter  int IW   = 16,
    parameter  int OW   = 16,
    parameter  int KMAX = 256,
    localparam int KW   = $clog2(KMAX) + 1,
    localparam int AW   = IW + guard_bits(KMAX)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [IW-1:0] in_data,
    input  logic [QW-1:0]        q_coef,
    input  logic [KW-1:0]        dly_k,
    input  logic [QW-1:0]        gain,
    input  logic [SHW-1:0]       gain_shift,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_data
);
    logic [KW-1:0]        k_seen;
    logic                 clr;
    logic                 v1, v2, v3;
    logic signed [AW-1:0] s1, s2, s3;
    scale_cfg_t           scfg;

    always_ff @(posedge clk) k_seen <= dly_k;

    always_comb begin
        clr        = rst | (dly_k != k_seen);
        scfg.gain  = gain;
        scfg.shift = gain_shift;
    end

    // Decay cancellation first: bounds everything downstream
    trap_pole_zero #(.IW(IW), .AW(AW)) u_pz (
        .clk(clk), .clr(clr), .in_v(in_valid), .x(in_data), .q(q_coef),
        .out_v(v1), .y(s1)
    );

    trap_delay_diff #(.AW(AW), .DEPTH(KMAX)) u_kdiff (
        .clk(clk), .clr(clr), .in_v(v1), .d(s1), .k(dly_k),
        .out_v(v2), .y(s2)
    );

    trap_first_diff #(.AW(AW)) u_fdiff (
        .clk(clk), .clr(clr), .in_v(v2), .d(s2),
        .out_v(v3), .y(s3)
    );

    // Integration last, where the signal is already narrow
    trap_accum_scale #(.AW(AW), .OW(OW)) u_acc (
        .clk(clk), .clr(clr), .in_v(v3), .d(s3), .cfg(scfg),
        .out_v(out_valid), .y(out_data)
    );
endmodule

// File: rtl/trap_shaper_checker.sv
module trap_shaper_checker #(
    parameter int KW = 9,
    parameter int OW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [KW-1:0] dly_k,
    input logic          out_valid,
    input logic [OW-1:0] out_data
);
    logic [KW-1:0] k_last;
    logic          k_moved;

    always_ff @(posedge clk) k_last <= dly_k;
    assign k_moved = (dly_k != k_last);

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst || k_moved)
        in_valid |-> ##4 out_valid);

    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 4));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(k_moved) && !$past(rst)) |-> $stable(out_data));

    assert_kchange_clear_R7: assert property (@(posedge clk) disable iff (rst)
        k_moved |=> (!out_valid && out_data == '0));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));
endmodule

bind trap_shaper trap_shaper_checker #(.KW(KW), .OW(OW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dly_k(dly_k),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/trap_shaper_bench.sv
`timescale 1ns/1ps
module trap_shaper_bench;
    localparam int IW = 16, OW = 16, KMAX = 256, KW = 9;

    typedef struct packed {
        logic signed [15:0] amp;
        logic [15:0]        q;
        logic [8:0]         k;
        logic [15:0]        gain;
        logic [3:0]         sh;
        logic               gap;
        logic signed [15:0] top;
    } vec_t;

    // amp, q, k, gain, shift, gaps, expected top
    localparam vec_t VECS [7] = '{
        '{16'sd1000,   16'd31130, 9'd8,   16'd32768, 4'd0, 1'b0, 16'sd1000},  // R3
        '{-16'sd2000,  16'd32000, 9'd16,  16'd16384, 4'd0, 1'b1, -16'sd1000}, // R4 R2
        '{16'sd3000,   16'd30000, 9'd3,   16'd32768, 4'd2, 1'b0, 16'sd750},   // R4
        '{16'sd7,      16'd32700, 9'd1,   16'd32768, 4'd1, 1'b1, 16'sd4},     // R4 half up
        '{-16'sd7,     16'd32700, 9'd1,   16'd32768, 4'd1, 1'b0, -16'sd3},    // R4 half up
        '{16'sd5000,   16'd32767, 9'd300, 16'd32768, 4'd0, 1'b0, 16'sd5000},  // R6 clamp
        '{16'sd1200,   16'd31000, 9'd0,   16'd32768, 4'd0, 1'b0, 16'sd1200}   // R6 zero
    };

    logic clk = 0, rst = 1, in_valid = 0;
    logic signed [IW-1:0] in_data = '0;
    logic [15:0] q_coef = '0, gain = 16'd32768;
    logic [KW-1:0] dly_k = 9'd1;
    logic [3:0] gain_shift = '0;
    logic out_valid;
    logic signed [OW-1:0] out_data;

    always #2 clk = ~clk;

    trap_shaper u_trap_shaper (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .q_coef(q_coef), .dly_k(dly_k), .gain(gain), .gain_shift(gain_shift),
        .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0, n_bad = 0;
    longint m_y1, m_xp, m_y2p, m_y3p, m_acc;
    longint m_ring [256];
    int m_wp;
    longint exq [8192];
    int exw = 0, exr = 0;
    longint cap [1024];
    int cap_n = 0;
    longint last_out;
    bit have_last = 0;
    vec_t v;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int k_eff(input int k);
        if (k == 0) return 1;
        if (k > 256) return 256;
        return k;
    endfunction

    task automatic model_clear();
        m_y1 = 0; m_xp = 0; m_y2p = 0; m_y3p = 0; m_acc = 0; m_wp = 0;
        for (int i = 0; i < 256; i++) m_ring[i] = 0;
        exr = exw; cap_n = 0; have_last = 0;
    endtask

    // Difference-equation model of the cascade (R9)
    task automatic model_push(input longint x);
        longint y2, y3, accn, r;
        int ke;
        ke = k_eff(int'(dly_k));
        m_y1 = m_y1 + x - ((longint'(q_coef) * m_xp) >>> 15);
        m_xp = x;
        y2 = m_y1 - m_ring[(m_wp - ke) & 255];
        m_ring[m_wp & 255] = m_y1;
        m_wp++;
        y3 = y2 - m_y2p;
        m_y2p = y2;
        accn = m_acc + m_y3p;
        m_acc = accn;
        m_y3p = y3;
        r = (accn * longint'(gain) + (64'sd1 <<< (14 + gain_shift))) >>> (15 + gain_shift);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        exq[exw] = r;
        exw++;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exr < exw) begin
                    check(longint'(out_data) == exq[exr], "R9", longint'(out_data), exq[exr]);
                    exr++;
                end else begin
                    check(1'b0, "R1", 1, 0);
                end
                cap[cap_n % 1024] = longint'(out_data);
                cap_n++;
                last_out = longint'(out_data);
                have_last = 1;
            end else if (have_last) begin
                check(longint'(out_data) == last_out, "R2", longint'(out_data), last_out);
            end
        end
    end

    task automatic feed(input longint x, input bit gap);
        @(negedge clk);
        in_valid = 1;
        in_data = 16'(x);
        model_push(x);
        if (gap) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    task automatic do_reset(input logic [15:0] q, input logic [8:0] k,
                            input logic [15:0] g, input logic [3:0] s);
        @(negedge clk);
        rst = 1; in_valid = 0;
        q_coef = q; dly_k = k; gain = g; gain_shift = s;
        @(negedge clk);
        rst = 0;
        model_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int cnt, hits;
        longint x, mx;
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R8", out_valid, 0);
        check(out_data == 0, "R8", out_data, 0);
        rst = 0;
        model_clear();

        // R1: latency in cycles from a single strobe
        do_reset(16'd0, 9'd1, 16'd32768, 4'd0);
        feed(100, 0);
        cnt = 0;
        do begin
            @(negedge clk);
            in_valid = 0;
            cnt++;
        end while (!out_valid && cnt < 10);
        check(cnt == 4, "R1", cnt, 4);
        idle(4);

        // Table of matched exponentials: R3, R4, R6 (gaps: R2)
        for (int i = 0; i < 7; i++) begin
            int ke, nfed;
            v = VECS[i];
            do_reset(v.q, v.k, v.gain, v.sh);
            ke = k_eff(int'(v.k));
            nfed = ke + 8;
            x = longint'(v.amp);
            for (int n = 0; n < nfed; n++) begin
                feed(x, v.gap);
                x = (x * longint'(v.q)) >>> 15;
            end
            idle(8);
            hits = 0;
            for (int n = 0; n < cap_n; n++)
                if (cap[n] == longint'(v.top)) hits++;
            check(hits == ke, "R3/R6 top width", hits, ke);
            check(cap_n == nfed, "R1 count", cap_n, nfed);
            check(cap[cap_n-1] == 0, "R3 baseline", cap[cap_n-1], 0);
            check(cap[0] == 0, "R3 start", cap[0], 0);
        end

        // R5: positive saturation with an integrating front stage
        do_reset(16'd0, 9'd4, 16'd32768, 4'd0);
        for (int n = 0; n < 8; n++) feed(20000, 0);
        idle(8);
        mx = -100000;
        for (int n = 0; n < cap_n; n++) if (cap[n] > mx) mx = cap[n];
        check(mx == 32767, "R5 high", mx, 32767);

        // R7: k change clears the whole pipeline
        @(negedge clk);
        dly_k = 9'd5;
        model_clear();
        @(negedge clk);
        check(out_data == 0, "R7", out_data, 0);
        check(out_valid == 0, "R7", out_valid, 0);
        for (int n = 0; n < 6; n++) feed(0, 0);
        idle(8);
        hits = 0;
        for (int n = 0; n < cap_n; n++) if (cap[n] == 0) hits++;
        check(hits == 6, "R7 zero after clear", hits, 6);

        // R5: negative saturation
        do_reset(16'd0, 9'd4, 16'd32768, 4'd0);
        for (int n = 0; n < 8; n++) feed(-20000, 0);
        idle(8);
        mx = 100000;
        for (int n = 0; n < cap_n; n++) if (cap[n] < mx) mx = cap[n];
        check(mx == -32768, "R5 low", mx, -32768);

        // R8: reset in the middle of a run
        do_reset(16'd0, 9'd4, 16'd32768, 4'd0);
        for (int n = 0; n < 6; n++) feed(5000, 0);
        idle(8);
        do_reset(16'd0, 9'd4, 16'd32768, 4'd0);
        check(out_data == 0, "R8", out_data, 0);
        check(out_valid == 0, "R8", out_valid, 0);
        for (int n = 0; n < 6; n++) feed(0, 0);
        idle(8);
        hits = 0;
        for (int n = 0; n < cap_n; n++) if (cap[n] == 0) hits++;
        check(hits == 6, "R8 zero after reset", hits, 6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule